// File: doc/BRIEF.md
# Half-Duplex Carrier and Receive-Own Monitor

This block sits beside the transmit and receive engines of an Ethernet MAC and watches the medium while a frame goes out. In half-duplex operation it tracks the PHY carrier-sense line across each transmission. It raises a sticky no-carrier flag when carrier never appeared during the frame, and a sticky loss-of-carrier flag when carrier went away after it had been seen. On the first such error of a frame it issues a one-cycle abort request to the transmitter. Each flag is cleared when the next transmission starts.

The block also decides what the receive MAC sees. In half-duplex operation it can hide the frames the PHY delivers while the MAC is itself transmitting, or pass everything through. Full-duplex operation disables both carrier checking and this suppression. In internal loopback the receive side is fed from the transmit side, and the PHY pins are neither driven nor sampled. Configuration is expected to stay stable for the whole of a frame.

Top module: `hd_carrier_monitor`

## Requirements
- R1: While `rst_n` is low, `err_loss_carrier`, `err_no_carrier` and `abort_req` are 0.
- R2: Carrier checking is active when `cfg_full_duplex`=0, `cfg_crs_ignore`=0 and `cfg_loopback`=0. With checking active, a transmission during which `phy_crs` is never 1 on any cycle with `tx_active`=1 sets `err_no_carrier` on the clock edge that ends the first cycle with `tx_active`=0.
- R3: With checking active, a cycle with `tx_active`=1 and `phy_crs`=0 that follows an earlier cycle of the same transmission with `phy_crs`=1 sets `err_loss_carrier` at the end of that cycle.
- R4: `abort_req` is a one-cycle pulse. It is high exactly in the cycle in which the first error flag of a transmission becomes 1, and it is never high on two consecutive cycles.
- R5: Both error flags hold their value until the clock edge that ends the first cycle of the next transmission (a cycle with `tx_active`=1 after a cycle with `tx_active`=0). At that edge they clear.
- R6: With `cfg_crs_ignore`=1 in half-duplex, `phy_crs` has no effect: no flag is set and no abort is issued.
- R7: With `cfg_full_duplex`=1 no carrier error or abort is generated.
- R8: In half-duplex (`cfg_full_duplex`=0) without loopback, if `cfg_own_block`=1 then `mac_rx_dv` is 0 while `tx_active`=1. Otherwise `mac_rx_dv` equals `phy_rx_dv` in the same cycle.
- R9: With `cfg_full_duplex`=1 and no loopback, `mac_rx_dv` equals `phy_rx_dv` whatever `cfg_own_block` and `tx_active` are.
- R10: With `cfg_loopback`=1, the following hold: `loop_sel`=1, `mac_rx_dv`=`tx_active`, `mac_rxd`=`tx_data`, `phy_tx_en`=0 and `phy_txd`=0. `phy_crs` is not sampled, so no carrier error arises.
- R11: Without loopback, `loop_sel`=0, `phy_tx_en`=`tx_active`, `phy_txd`=`tx_data` and `mac_rxd`=`phy_rxd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_full_duplex | input | 1 | 1 = full duplex |
| cfg_crs_ignore | input | 1 | 1 = ignore carrier sense during transmission |
| cfg_own_block | input | 1 | 1 = hide received frames while transmitting (half duplex) |
| cfg_loopback | input | 1 | 1 = internal loopback |
| tx_active | input | 1 | Transmit engine is sending a frame |
| tx_data | input | DATA_W | Transmit data from the MAC |
| phy_crs | input | 1 | Carrier sense from the PHY |
| phy_rx_dv | input | 1 | Receive data valid from the PHY |
| phy_rxd | input | DATA_W | Receive data from the PHY |
| phy_tx_en | output | 1 | Transmit enable towards the PHY |
| phy_txd | output | DATA_W | Transmit data towards the PHY |
| mac_rx_dv | output | 1 | Gated receive valid to the receive MAC |
| mac_rxd | output | DATA_W | Receive data to the receive MAC |
| loop_sel | output | 1 | Receive path taken from the transmit side |
| abort_req | output | 1 | One-cycle request to abort the current frame |
| err_loss_carrier | output | 1 | Sticky loss-of-carrier flag for the latest frame |
| err_no_carrier | output | 1 | Sticky no-carrier flag for the latest frame |

## Verification
The bench builds the block with its default `DATA_W` of 8. At that width random transmit and receive bytes make a wrong data source in either mux show up within a few cycles. Each random frame draws a fresh combination of the four mode bits. It also draws a carrier pattern: silent, steady, dropping part way, or random. Together these reach no-carrier, loss-of-carrier, sticky clearing at the next frame and every precedence between loopback, duplex, carrier ignore and own-frame suppression. Directed frames first pin down each error kind and its abort pulse.

// File: rtl/hdmon_pkg.sv
package hdmon_pkg;

  typedef struct packed {
    logic full_duplex;
    logic crs_ignore;
    logic own_block;
    logic loopback;
  } hd_cfg_t;

  // Carrier supervision only runs in half duplex, not ignored, pins sampled.
  function automatic logic carrier_check_on(hd_cfg_t c);
    return !c.full_duplex && !c.crs_ignore && !c.loopback;
  endfunction

  // Own-frame suppression applies only in half duplex during transmission.
  function automatic logic own_suppress(hd_cfg_t c, logic tx);
    return !c.full_duplex && c.own_block && tx;
  endfunction

endpackage

// File: rtl/hd_tx_tracker.sv
module hd_tx_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic crs_eff,
  output logic tx_start,
  output logic tx_end,
  output logic crs_seen
);
  logic tx_q;

  assign tx_start = tx_active && !tx_q;
  assign tx_end   = !tx_active && tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= 1'b0;
      crs_seen <= 1'b0;
    end else begin
      tx_q <= tx_active;
      if (tx_start)
        crs_seen <= crs_eff;
      else if (tx_active && crs_eff)
        crs_seen <= 1'b1;
    end
  end

  assert_start_end_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_start && tx_end));

endmodule

// File: rtl/hd_carrier_check.sv
module hd_carrier_check (
  input  logic clk,
  input  logic rst_n,
  input  logic check_on,
  input  logic tx_active,
  input  logic tx_start,
  input  logic tx_end,
  input  logic crs_eff,
  input  logic crs_seen,
  output logic loss_ev,
  output logic noc_ev,
  output logic err_loss,
  output logic err_noc,
  output logic abort_req
);
  logic any_err;

  assign loss_ev = check_on && tx_active && !tx_start && crs_seen && !crs_eff;
  assign noc_ev  = check_on && tx_end && !crs_seen;
  assign any_err = err_loss || err_noc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_loss  <= 1'b0;
      err_noc   <= 1'b0;
      abort_req <= 1'b0;
    end else begin
      err_loss  <= (err_loss && !tx_start) || loss_ev;
      err_noc   <= (err_noc && !tx_start) || noc_ev;
      abort_req <= (loss_ev || noc_ev) && !any_err;
    end
  end

  assert_abort_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req);
  assert_abort_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> (err_loss || err_noc));
  assert_clear_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> (!err_loss && !err_noc));
  assert_loss_needs_check_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_loss) |-> $past(check_on));
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_loss && err_noc));

endmodule

// File: rtl/hd_rx_gate.sv
module hd_rx_gate
  import hdmon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hd_cfg_t           cfg,
  input  logic              tx_active,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              phy_crs,
  input  logic              phy_rx_dv,
  input  logic [DATA_W-1:0] phy_rxd,
  output logic              crs_eff,
  output logic              phy_tx_en,
  output logic [DATA_W-1:0] phy_txd,
  output logic              mac_rx_dv,
  output logic [DATA_W-1:0] mac_rxd,
  output logic              loop_sel
);
  logic suppress;

  assign suppress = own_suppress(cfg, tx_active);
  assign loop_sel = cfg.loopback;
  assign crs_eff  = phy_crs && !cfg.loopback;

  always_comb begin
    if (cfg.loopback) begin
      mac_rx_dv = tx_active;
      mac_rxd   = tx_data;
      phy_tx_en = 1'b0;
      phy_txd   = '0;
    end else begin
      mac_rx_dv = phy_rx_dv && !suppress;
      mac_rxd   = phy_rxd;
      phy_tx_en = tx_active;
      phy_txd   = tx_data;
    end
  end

  assert_loop_pins_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    loop_sel |-> (!phy_tx_en && phy_txd == '0));
  assert_own_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_sel && !cfg.full_duplex && cfg.own_block && tx_active) |-> !mac_rx_dv);
  assert_fd_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_sel && cfg.full_duplex) |-> (mac_rx_dv == phy_rx_dv));

endmodule

// File: rtl/hd_carrier_monitor.sv
module hd_carrier_monitor
  import hdmon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_full_duplex,
  input  logic              cfg_crs_ignore,
  input  logic              cfg_own_block,
  input  logic              cfg_loopback,
  input  logic              tx_active,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              phy_crs,
  input  logic              phy_rx_dv,
  input  logic [DATA_W-1:0] phy_rxd,
  output logic              phy_tx_en,
  output logic [DATA_W-1:0] phy_txd,
  output logic              mac_rx_dv,
  output logic [DATA_W-1:0] mac_rxd,
  output logic              loop_sel,
  output logic              abort_req,
  output logic              err_loss_carrier,
  output logic              err_no_carrier
);
  hd_cfg_t cfg;
  logic    check_on;
  logic    crs_eff;
  logic    tx_start;
  logic    tx_end;
  logic    crs_seen;
  logic    loss_ev;
  logic    noc_ev;

  assign cfg = '{full_duplex: cfg_full_duplex, crs_ignore: cfg_crs_ignore,
                 own_block: cfg_own_block, loopback: cfg_loopback};
  assign check_on = carrier_check_on(cfg);

  hd_rx_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .tx_active(tx_active), .tx_data(tx_data),
    .phy_crs(phy_crs), .phy_rx_dv(phy_rx_dv), .phy_rxd(phy_rxd), .crs_eff(crs_eff),
    .phy_tx_en(phy_tx_en), .phy_txd(phy_txd), .mac_rx_dv(mac_rx_dv),
    .mac_rxd(mac_rxd), .loop_sel(loop_sel)
  );

  hd_tx_tracker u_track (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .crs_eff(crs_eff),
    .tx_start(tx_start), .tx_end(tx_end), .crs_seen(crs_seen)
  );

  hd_carrier_check u_check (
    .clk(clk), .rst_n(rst_n), .check_on(check_on), .tx_active(tx_active),
    .tx_start(tx_start), .tx_end(tx_end), .crs_eff(crs_eff), .crs_seen(crs_seen),
    .loss_ev(loss_ev), .noc_ev(noc_ev), .err_loss(err_loss_carrier),
    .err_noc(err_no_carrier), .abort_req(abort_req)
  );

  assert_noc_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    noc_ev |=> err_no_carrier);
  assert_loss_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loss_ev |-> tx_active);
  assert_fd_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_full_duplex |-> (!loss_ev && !noc_ev));

endmodule

// File: tb/hd_carrier_monitor_test.sv
module hd_carrier_monitor_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fd = 0, ign = 0, blk = 0, lb = 0;
  logic tx = 0, crs = 0, rdv = 0;
  logic [W-1:0] txd = '0, rxd = '0;
  logic ptx_en, lsel, abort, eloss, enoc, mrdv;
  logic [W-1:0] ptxd, mrxd;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // model state
  bit m_txq, m_seen, m_loss, m_noc, m_abort;

  always #2 clk = ~clk;

  hd_carrier_monitor #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_full_duplex(fd), .cfg_crs_ignore(ign),
    .cfg_own_block(blk), .cfg_loopback(lb), .tx_active(tx), .tx_data(txd),
    .phy_crs(crs), .phy_rx_dv(rdv), .phy_rxd(rxd), .phy_tx_en(ptx_en),
    .phy_txd(ptxd), .mac_rx_dv(mrdv), .mac_rxd(mrxd), .loop_sel(lsel),
    .abort_req(abort), .err_loss_carrier(eloss), .err_no_carrier(enoc)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_check_on();
    return !fd && !ign && !lb;
  endfunction

  function automatic bit exp_rx_dv();
    if (lb) return tx;
    if (!fd && blk && tx) return 1'b0;
    return rdv;
  endfunction

  function automatic string err_tag(input bit loss);
    if (lb) return "R10";
    if (fd) return "R7";
    if (ign) return "R6";
    return loss ? "R3" : "R2";
  endfunction

  task automatic model_update();
    bit start, endf, ce, lev, nev;
    start = tx && !m_txq;
    endf  = !tx && m_txq;
    ce    = crs && !lb;
    lev   = exp_check_on() && tx && !start && m_seen && !ce;
    nev   = exp_check_on() && endf && !m_seen;
    m_abort = (lev || nev) && !(m_loss || m_noc);
    m_loss  = (m_loss && !start) || lev;
    m_noc   = (m_noc && !start) || nev;
    if (start) m_seen = ce;
    else if (tx && ce) m_seen = 1'b1;
    m_txq = tx;
  endtask

  task automatic check_all();
    string rt;
    chk(err_tag(1), "err_loss_carrier", W'(eloss), W'(m_loss));
    chk(err_tag(0), "err_no_carrier", W'(enoc), W'(m_noc));
    chk("R4", "abort_req", W'(abort), W'(m_abort));
    rt = lb ? "R10" : (fd ? "R9" : "R8");
    chk(rt, "mac_rx_dv", W'(mrdv), W'(exp_rx_dv()));
    rt = lb ? "R10" : "R11";
    chk(rt, "mac_rxd", mrxd, lb ? txd : rxd);
    chk(rt, "phy_tx_en", W'(ptx_en), W'(lb ? 1'b0 : tx));
    chk(rt, "phy_txd", ptxd, lb ? '0 : txd);
    chk(rt, "loop_sel", W'(lsel), W'(lb));
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_all();
    txd = W'($urandom);
    rxd = W'($urandom);
    rdv = 1'($urandom);
  endtask

  // pattern: 0 silent, 1 steady, 2 drop part way, 3 random
  task automatic frame(input int len, input int pat);
    int drop;
    drop = 1 + ($urandom % len);
    step(); step();
    for (int i = 0; i < len; i++) begin
      tx = 1'b1;
      case (pat)
        0: crs = 1'b0;
        1: crs = 1'b1;
        2: crs = (i < drop);
        default: crs = 1'($urandom);
      endcase
      step();
    end
    tx = 1'b0;
    crs = 1'($urandom);
    step(); step();
  endtask

  task automatic set_cfg(input bit f, input bit i, input bit b, input bit l);
    fd = f; ign = i; blk = b; lb = l;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "err_loss_carrier", W'(eloss), '0);
    chk("R1", "err_no_carrier", W'(enoc), '0);
    chk("R1", "abort_req", W'(abort), '0);
    rst_n = 1'b1;

    // R2: silent carrier, abort pulse (R4)
    set_cfg(0, 0, 0, 0);
    frame(6, 0);
    chk("R2", "err_no_carrier sticky", W'(enoc), 8'd1);
    // R5: next frame start clears it
    step(); tx = 1'b1; crs = 1'b1; step();
    chk("R5", "err_no_carrier cleared", W'(enoc), 8'd0);
    // R3: carrier drops mid-frame
    step(); crs = 1'b0; step();
    chk("R3", "err_loss_carrier set", W'(eloss), 8'd1);
    chk("R4", "abort pulse", W'(abort), 8'd1);
    step();
    chk("R4", "abort single", W'(abort), 8'd0);
    tx = 1'b0; step(); step();
    // R6 ignore, R7 full duplex, R10 loopback, R8 own block
    set_cfg(0, 1, 0, 0); frame(5, 0); frame(5, 2);
    chk("R6", "no flag when ignored", W'(eloss | enoc), 8'd0);
    set_cfg(1, 0, 1, 0); frame(5, 0);
    chk("R7", "no flag in full duplex", W'(eloss | enoc), 8'd0);
    set_cfg(0, 0, 0, 1); frame(5, 0);
    chk("R10", "no flag in loopback", W'(eloss | enoc), 8'd0);
    set_cfg(0, 1, 1, 0); frame(8, 1);

    for (int k = 0; k < 400; k++) begin
      set_cfg(($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom), ($urandom % 5) == 0);
      frame(1 + ($urandom % 12), $urandom % 4);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule